// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Host-Supplied Parity

This block turns a parallel word from a register front end into an asynchronous serial frame on a single output line. A one-word holding buffer accepts the word, its parity bit and nothing else. The word waits there until the shift stage is free, then moves across and goes out. Each frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit whose value the host chose, then a high stop bit. The line rests high between frames.

Bit timing comes from the block's own clock. A free-running prescaler divides that clock by a power of two picked by a 4-bit code. Each prescaler tick is one sixteenth of a bit. A buffer-empty flag tells the host when another word may be written, and it can serve as an interrupt source.

A shutdown input stops everything at once. The line goes high in the same cycle. The frame in flight is dropped, the buffer is cleared and writes are refused. Normal operation starts again when shutdown is released.

Top module: `uart_host_tx`

## Requirements
- R1: With divisor code n on `div_code`, every serial bit, including the start bit, holds for exactly 16·2^n clock cycles. The prescaler starts counting from reset and again from the end of shutdown.
- R2: Each frame begins with a start bit of 0 and ends with a stop bit of 1. Data bits go out least significant bit first. `tx` is 1 whenever no frame is being sent.
- R3: When `len8` is 1 the frame carries `wr_data[7:0]`. When `len8` is 0 it carries `wr_data[6:0]` and bit 7 is not sent. `len8` is sampled when the word moves from the buffer into the shift stage.
- R4: When `par_on` is 1, the frame carries the `wr_par` value given with the word. This bit goes right after the last data bit and is sent as given, not recomputed. When `par_on` is 0 there is no parity slot. `par_on` is sampled at the same moment as `len8`.
- R5: `tbe` is 1 while the buffer is empty. It goes to 0 in the cycle after a write is accepted. It returns to 1 in the cycle after the word moves into the shift stage.
- R6: A write made while `tbe` is 0 is ignored. The buffered word and the frames sent do not change.
- R7: A word that is waiting in the buffer when a stop bit ends starts its start bit at once, with no idle time between the two frames.
- R8: While `shdn` is 1, `tx` is 1 in the same cycle. The frame in progress is abandoned, the buffer is emptied so that `tbe` reads 1, and writes are ignored.
- R9: After reset `tx` is 1 and `tbe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn | input | 1 | Shutdown, active high, aborts at once |
| div_code | input | 4 | Divisor code n, divide by 2^n |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_on | input | 1 | 1: include the host parity bit |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Data word to send |
| wr_par | input | 1 | Parity bit value to send |
| tx | output | 1 | Serial output, idles high |
| tbe | output | 1 | Holding buffer empty |

## Verification
The data values are chosen so that each one exposes a different fault. An alternating pattern reveals bit order. A value with bit 7 set, sent in 7-bit mode, reveals a leaked top bit. Parity values that disagree with the data's real parity reveal any hidden parity computation. A start bit followed by a 1 lets the bench measure the bit length exactly for several divisor codes. Back-to-back writes, with a third write landing while the buffer is full, separate gap-free chaining from dropped or overwritten words. A shutdown pulse in the middle of a frame, while a word waits in the buffer, shows whether the abort is immediate and whether the buffer is cleared.

// File: rtl/uart_host_tx.sv
module uart_host_tx #(
  parameter int CODE_W = 4,
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn,
  input  logic [CODE_W-1:0] div_code,
  input  logic              len8,
  input  logic              par_on,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  output logic              tx,
  output logic              tbe
);
  localparam int PRE_W = (1 << CODE_W) - 1;
  localparam int SUB_W = $clog2(OVS);
  localparam int FR_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(FR_W + 1);
  localparam logic [PRE_W:0]   ONE  = {{PRE_W{1'b0}}, 1'b1};
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);
  localparam logic [CNT_W-1:0] C1   = CNT_W'(1);

  logic [PRE_W-1:0]  pre;
  logic [PRE_W:0]    lim;
  logic              tick;
  logic [SUB_W-1:0]  sub;
  logic [CNT_W-1:0]  left;
  logic [FR_W-1:0]   shreg, fr;
  logic [CNT_W-1:0]  nbits;
  logic              active, buf_full, buf_par, load, last_tick;
  logic [DATA_W-1:0] buf_data;

  assign lim       = (ONE << div_code) - ONE;
  assign tick      = ({1'b0, pre} >= lim);
  assign last_tick = tick && active && sub == LAST && left == C1;
  assign load      = tick && buf_full && (!active || (sub == LAST && left == C1));

  always_comb begin
    int len;
    len = len8 ? DATA_W : DATA_W - 1;
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < len) fr[i+1] = buf_data[i];
    if (par_on) fr[len+1] = buf_par;
    nbits = CNT_W'(len + 2 + (par_on ? 1 : 0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; sub <= '0; left <= '0; shreg <= '1; active <= 1'b0;
      buf_full <= 1'b0; buf_data <= '0; buf_par <= 1'b0;
    end else if (shdn) begin
      pre <= '0; sub <= '0; left <= '0; shreg <= '1; active <= 1'b0;
      buf_full <= 1'b0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (load) begin
        shreg  <= fr;
        left   <= nbits;
        sub    <= '0;
        active <= 1'b1;
      end else if (tick && active) begin
        if (sub != LAST) sub <= sub + 1'b1;
        else if (left > C1) begin
          shreg <= {1'b1, shreg[FR_W-1:1]};
          left  <= left - C1;
          sub   <= '0;
        end else active <= 1'b0;
      end
      if (load) buf_full <= 1'b0;
      if (wr_en && !buf_full) begin
        buf_full <= 1'b1;
        buf_data <= wr_data;
        buf_par  <= wr_par;
      end
    end
  end

  assign tx  = shdn | ~active | shreg[0];
  assign tbe = ~buf_full;

  assert_bit_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active && !tick && !shdn |=> $stable(tx));
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !tx);
  assert_tbe_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tbe && wr_en && !shdn |=> !tbe);
  assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !load && !shdn |=> $stable(buf_data) && $stable(buf_par));
  assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick && buf_full && !shdn |=> active && !tx);
  assert_shdn_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> !active && tbe);
endmodule

// File: tb/uart_host_tx_bench.sv
module uart_host_tx_bench;
  localparam int CLK_NS = 10;
  localparam int WDOG   = 150000;

  logic       clk = 0, rst_n = 0, shdn = 0, len8 = 1, par_on = 0;
  logic [3:0] div_code = 0;
  logic       wr_en = 0, wr_par = 0;
  logic [7:0] wr_data = 0;
  logic       tx, tbe;

  uart_host_tx u_uart_host_tx (.clk(clk), .rst_n(rst_n), .shdn(shdn), .div_code(div_code),
    .len8(len8), .par_on(par_on), .wr_en(wr_en), .wr_data(wr_data), .wr_par(wr_par),
    .tx(tx), .tbe(tbe));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R9";
  bit bitq[$];
  int pre_m = 0, cnt_m = 0;
  bit pend = 0, pp = 0;
  logic [7:0] pd = 0;

  always @(posedge clk) begin
    bit old_pend, tk;
    int lim_m, n;
    old_pend = pend;
    if (!rst_n || shdn) begin
      bitq.delete(); pend = 0; pre_m = 0; cnt_m = 0;
    end else begin
      lim_m = (1 << div_code) - 1;
      tk = pre_m >= lim_m;
      pre_m = tk ? 0 : pre_m + 1;
      if (tk) begin
        if (bitq.size() > 0) begin
          cnt_m++;
          if (cnt_m == 16) begin void'(bitq.pop_front()); cnt_m = 0; end
        end
        if (bitq.size() == 0 && old_pend) begin
          n = len8 ? 8 : 7;
          bitq.push_back(1'b0);
          for (int i = 0; i < n; i++) bitq.push_back(pd[i]);
          if (par_on) bitq.push_back(pp);
          bitq.push_back(1'b1);
          pend = 0; cnt_m = 0;
        end
      end
      if (wr_en && !old_pend) begin pend = 1; pd = wr_data; pp = wr_par; end
    end
  end

  always @(negedge clk) begin
    bit et;
    cycles++;
    if (rst_n) begin
      et = shdn ? 1'b1 : (bitq.size() == 0 ? 1'b1 : bitq[0]);
      checks++;
      if (tx !== et || tbe !== !pend) begin
        fails++;
        $display("FAIL %s cycle %0d: tx=%b tbe=%b expected tx=%b tbe=%b", tag, cycles, tx, tbe, et, !pend);
      end
    end
    if (cycles > WDOG) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic p);
    @(negedge clk); #1; wr_en = 1; wr_data = d; wr_par = p;
    @(negedge clk); #1; wr_en = 0;
  endtask

  task automatic drain();
    int k = 0;
    while ((bitq.size() != 0 || pend) && k < 40000) begin @(negedge clk); k++; end
    repeat (20) @(negedge clk);
  endtask

  task automatic start_len(input logic [3:0] code, input int exp);
    int k = 0, w = 0;
    @(negedge clk); #1; div_code = code; len8 = 1; par_on = 0;
    wr(8'h01, 0);
    while (tx === 1'b1 && w < 20000) begin @(negedge clk); w++; end
    while (tx === 1'b0 && k < 20000) begin @(negedge clk); k++; end
    chk("R1 start bit length", k, exp);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 tx after reset", int'(tx), 1);
    chk("R9 tbe after reset", int'(tbe), 1);
    #1 rst_n = 1;
    repeat (5) @(negedge clk);

    tag = "R1"; start_len(0, 16); start_len(1, 32); start_len(3, 128);

    tag = "R2"; @(negedge clk); #1; div_code = 0; len8 = 1; par_on = 0;
    wr(8'hA5, 0); drain(); wr(8'h3C, 1); drain();

    tag = "R3"; @(negedge clk); #1; len8 = 0; div_code = 1;
    wr(8'hDA, 0); drain();

    tag = "R4"; @(negedge clk); #1; par_on = 1;
    wr(8'h5A, 1); drain();
    @(negedge clk); #1; len8 = 1;
    wr(8'h07, 0); drain();

    tag = "R5"; @(negedge clk); #1; div_code = 0; par_on = 0;
    @(negedge clk); #1; wr_en = 1; wr_data = 8'h81;
    @(negedge clk); chk("R5 tbe after write", int'(tbe), 0); #1; wr_en = 0;
    drain(); chk("R5 tbe after drain", int'(tbe), 1);

    tag = "R6"; wr(8'h11, 0); wr(8'h22, 0); wr(8'h33, 0);
    chk("R6 tbe while full", int'(tbe), 0); drain();

    tag = "R7"; @(negedge clk); #1; par_on = 1;
    wr(8'hF0, 1); wr(8'h0F, 0); wr(8'hC3, 1); drain();

    tag = "R8"; @(negedge clk); #1; div_code = 2; par_on = 0;
    wr(8'h3C, 0); wr(8'h99, 0);
    repeat (300) @(negedge clk);
    #1 shdn = 1;
    #1 chk("R8 tx during shutdown", int'(tx), 1);
    wr(8'h55, 0);
    repeat (5) @(negedge clk);
    chk("R8 tbe during shutdown", int'(tbe), 1);
    #1 shdn = 0;
    repeat (400) @(negedge clk);
    chk("R8 tx idle after release", int'(tx), 1);
    chk("R8 buffer cleared", int'(tbe), 1);
    wr(8'h6E, 1); drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule